// File: doc/BRIEF.md
# Decoder Address-to-Port Router

This block stores a small bank of memory-range decoder register sets and uses them to route a host address to a downstream port number. Each decoder set holds a base, a size, a control word and a list of eight 8-bit port numbers. A capability register selects how many decoders take part in the search.

For each lookup, the decoders are searched in index order. The first active decoder whose range contains the address is the only one used. That decoder must be committed, or the lookup is a miss. From the address, the decoder's granularity and its interleave-ways setting, the block works out a position between 0 and 7. It returns the port number stored at that position, together with a hit flag. The result appears one cycle after the request, and a new lookup can be issued every cycle.

Software or a configuration agent loads the registers through a plain write port. Each write selects a decoder, a word within that decoder and the data.

Top module: `hdm_route_lookup`

## Requirements
- R1: A lookup requested with `lk_valid` high is answered on `res_valid`, `res_hit` and `res_port` in the cycle after the request edge.
- R2: In a cycle where no lookup was requested, the next cycle shows `res_valid`, `res_hit` and `res_port` all at 0.
- R3: The register write port uses these `wr_sel` codes, each taking effect at the write edge: 0 base low, 1 base high, 2 size low, 3 size high, 4 control, 5 port list low, 6 port list high. Code 7 writes the capability word, and `wr_idx` is ignored for it.
- R4: The base and the size are each the 64-bit value {high word, low word bits 31:28, 28 zero bits}. Bits 27:0 of the low words have no effect.
- R5: A decoder matches when base <= address < base + size.
- R6: When several active decoders match, the one with the lowest index is the only one used.
- R7: If that first matching decoder has control bit 10 (committed) clear, the result is a miss with port 0, even when a later decoder would match.
- R8: The position is (address >> (8 + g)) modulo 2^w. Here g is control bits 3:0, and w is control bits 7:4 limited to 3.
- R9: Positions 0 to 3 select byte 0 to 3 (bits 8p+7:8p) of the low port-list word. Positions 4 to 7 select byte p-4 of the high port-list word.
- R10: Capability bits 3:0 encode the number of active decoders: 0 means 1, 1 means 2, 2 means 4, 3 means 6 and 4 means 8. Any other value means none. Decoders at or above the active count never match.
- R11: An address that matches no active decoder gives a miss with port 0.
- R12: After reset, every register is 0 and all outputs are 0. With every decoder uncommitted, any lookup is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Decoder index for the write |
| wr_sel | input | 3 | Word selector within the decoder, or 7 for the capability word |
| wr_data | input | 32 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Host address to route |
| res_valid | output | 1 | Lookup answer valid |
| res_hit | output | 1 | Address routed to a committed decoder |
| res_port | output | 8 | Selected downstream port number |

## Verification
Register writes change the routing from the edge that takes the write. A lookup is due one edge after its request. The bench therefore drives each write or request at a falling edge and waits through one rising edge before going on. It samples the answer at the next falling edge, where `res_valid`, `res_hit` and `res_port` must all agree with the bench's model. Writes and lookups are never issued in the same cycle, so every answer reflects the register state in place before the request.

// File: rtl/hdm_pkg.sv
package hdm_pkg;

    localparam int WORD_W = 32;
    localparam int PORT_W = 8;
    localparam int COMMIT_BIT = 10;

    typedef enum logic [2:0] {
        SEL_BASE_LO = 3'd0,
        SEL_BASE_HI = 3'd1,
        SEL_SIZE_LO = 3'd2,
        SEL_SIZE_HI = 3'd3,
        SEL_CTRL    = 3'd4,
        SEL_TGT_LO  = 3'd5,
        SEL_TGT_HI  = 3'd6,
        SEL_CAP     = 3'd7
    } wsel_e;

    typedef struct packed {
        logic [WORD_W-1:0] tgt_hi;
        logic [WORD_W-1:0] tgt_lo;
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] size_hi;
        logic [WORD_W-1:0] size_lo;
        logic [WORD_W-1:0] base_hi;
        logic [WORD_W-1:0] base_lo;
    } dec_regs_t;

    // Encoded decoder count to number of decoders; 0 for unknown codes.
    function automatic logic [3:0] count_decode(input logic [3:0] enc);
        logic [3:0] n;
        case (enc)
            4'd0: n = 4'd1;
            4'd1: n = 4'd2;
            4'd2: n = 4'd4;
            4'd3: n = 4'd6;
            4'd4: n = 4'd8;
            default: n = 4'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/hdm_regfile.sv
module hdm_regfile
    import hdm_pkg::*;
#(
    parameter int NUM_DEC = 8,
    localparam int IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_idx,
    input  logic [2:0]                 wr_sel,
    input  logic [WORD_W-1:0]          wr_data,
    output dec_regs_t [NUM_DEC-1:0]    dec_regs,
    output logic [NUM_DEC-1:0]         dec_active
);

    typedef struct packed {
        dec_regs_t [NUM_DEC-1:0] dec;
        logic [WORD_W-1:0]       cap;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic [3:0] cnt;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_sel == SEL_CAP) begin
                st_d.cap = wr_data;
            end else if (32'(wr_idx) < NUM_DEC) begin
                case (wsel_e'(wr_sel))
                    SEL_BASE_LO: st_d.dec[wr_idx[IDX_W-1:0]].base_lo = wr_data;
                    SEL_BASE_HI: st_d.dec[wr_idx[IDX_W-1:0]].base_hi = wr_data;
                    SEL_SIZE_LO: st_d.dec[wr_idx[IDX_W-1:0]].size_lo = wr_data;
                    SEL_SIZE_HI: st_d.dec[wr_idx[IDX_W-1:0]].size_hi = wr_data;
                    SEL_CTRL:    st_d.dec[wr_idx[IDX_W-1:0]].ctrl    = wr_data;
                    SEL_TGT_LO:  st_d.dec[wr_idx[IDX_W-1:0]].tgt_lo  = wr_data;
                    SEL_TGT_HI:  st_d.dec[wr_idx[IDX_W-1:0]].tgt_hi  = wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_regs = st_q.dec;
    assign cnt      = count_decode(st_q.cap[3:0]);

    generate
        for (genvar i = 0; i < NUM_DEC; i++) begin : g_act
            assign dec_active[i] = (32'(i) < 32'(cnt));
        end
    endgenerate

    // R10: an unknown count code leaves no decoder active
    assert_bad_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd7 && wr_data[3:0] > 4'd4) |=> (dec_active == '0));

endmodule

// File: rtl/hdm_range_match.sv
module hdm_range_match
    import hdm_pkg::*;
#(
    parameter int NUM_DEC = 8,
    parameter int ADDR_W  = 64,
    localparam int GRAIN  = 28,
    localparam int CH_W   = ADDR_W - GRAIN
) (
    input  logic [ADDR_W-1:0]       addr,
    input  dec_regs_t [NUM_DEC-1:0] dec_regs,
    input  logic [NUM_DEC-1:0]      dec_active,
    output logic [NUM_DEC-1:0]      in_range
);

    logic [CH_W-1:0] a_ch;
    assign a_ch = addr[ADDR_W-1:GRAIN];

    generate
        for (genvar i = 0; i < NUM_DEC; i++) begin : g_cmp
            logic [63:0]     base_w, size_w;
            logic [CH_W-1:0] base_c, size_c;
            logic [CH_W:0]   lim_c;
            assign base_w = {dec_regs[i].base_hi, dec_regs[i].base_lo[31:GRAIN], 28'd0};
            assign size_w = {dec_regs[i].size_hi, dec_regs[i].size_lo[31:GRAIN], 28'd0};
            assign base_c = base_w[GRAIN +: CH_W];
            assign size_c = size_w[GRAIN +: CH_W];
            assign lim_c  = {1'b0, base_c} + {1'b0, size_c};
            assign in_range[i] = dec_active[i] && (a_ch >= base_c) && ({1'b0, a_ch} < lim_c);
        end
    endgenerate

endmodule

// File: rtl/hdm_port_pick.sv
module hdm_port_pick
    import hdm_pkg::*;
#(
    parameter int NUM_DEC = 8,
    parameter int ADDR_W  = 64
) (
    input  logic [ADDR_W-1:0]       addr,
    input  dec_regs_t [NUM_DEC-1:0] dec_regs,
    input  logic [NUM_DEC-1:0]      in_range,
    output logic                    hit,
    output logic [PORT_W-1:0]       port
);

    dec_regs_t  win;
    logic       found;
    logic [3:0] ways;
    logic [2:0] pos;
    logic [ADDR_W-1:0] shifted;

    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < NUM_DEC; i++) begin
            if (!found && in_range[i]) begin
                found = 1'b1;
                win   = dec_regs[i];
            end
        end
        ways    = (win.ctrl[7:4] > 4'd3) ? 4'd3 : win.ctrl[7:4];
        shifted = addr >> (5'd8 + {1'b0, win.ctrl[3:0]});
        pos     = shifted[2:0] & 3'((4'd1 << ways) - 4'd1);
        hit     = found && win.ctrl[COMMIT_BIT];
        port    = '0;
        if (hit) begin
            if (!pos[2]) port = win.tgt_lo[{pos[1:0], 3'b000} +: PORT_W];
            else         port = win.tgt_hi[{pos[1:0], 3'b000} +: PORT_W];
        end
    end

endmodule

// File: rtl/hdm_route_lookup.sv
module hdm_route_lookup
    import hdm_pkg::*;
#(
    parameter int NUM_DEC = 8,
    parameter int ADDR_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [7:0]        res_port
);

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic [PORT_W-1:0] port;
    } res_t;

    dec_regs_t [NUM_DEC-1:0] dec_regs;
    logic [NUM_DEC-1:0]      dec_active;
    logic [NUM_DEC-1:0]      in_range;
    logic                    pick_hit;
    logic [PORT_W-1:0]       pick_port;
    res_t                    res_d, res_q;

    hdm_regfile #(.NUM_DEC(NUM_DEC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .dec_regs(dec_regs), .dec_active(dec_active)
    );

    hdm_range_match #(.NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W)) u_match (
        .addr(lk_addr), .dec_regs(dec_regs), .dec_active(dec_active),
        .in_range(in_range)
    );

    hdm_port_pick #(.NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W)) u_pick (
        .addr(lk_addr), .dec_regs(dec_regs), .in_range(in_range),
        .hit(pick_hit), .port(pick_port)
    );

    always_comb begin
        res_d = '0;
        if (lk_valid) begin
            res_d.vld  = 1'b1;
            res_d.hit  = pick_hit;
            res_d.port = pick_port;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.vld;
    assign res_hit   = res_q.hit;
    assign res_port  = res_q.port;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_idle_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && !res_hit && res_port == '0));

    assert_hit_needs_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && in_range == '0) |=> !res_hit);

endmodule

// File: tb/hdm_route_lookup_bench.sv
module hdm_route_lookup_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        res_valid, res_hit;
    logic [7:0]  res_port;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] m_reg [8][7];
    logic [31:0] m_cap;

    always #2 clk = ~clk;

    hdm_route_lookup u_hdm_route_lookup (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_sel(wr_sel), .wr_data(wr_data), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .res_valid(res_valid), .res_hit(res_hit),
        .res_port(res_port)
    );

    initial begin
        #400000;
        n_errors++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    function automatic int ref_count(input logic [3:0] e);
        case (e)
            4'd0: return 1;
            4'd1: return 2;
            4'd2: return 4;
            4'd3: return 6;
            4'd4: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic logic [8:0] ref_lookup(input logic [63:0] a);
        int cnt = ref_count(m_cap[3:0]);
        for (int i = 0; i < cnt; i++) begin
            logic [63:0] b = {m_reg[i][1], m_reg[i][0][31:28], 28'd0};
            logic [63:0] s = {m_reg[i][3], m_reg[i][2][31:28], 28'd0};
            logic [64:0] lim = {1'b0, b} + {1'b0, s};
            if (a >= b && {1'b0, a} < lim) begin
                logic [31:0] c = m_reg[i][4];
                int w = (c[7:4] > 3) ? 3 : int'(c[7:4]);
                int p = int'((a >> (8 + c[3:0])) % (64'd1 << w));
                if (!c[10]) return 9'd0;
                if (p < 4) return {1'b1, m_reg[i][5][p*8 +: 8]};
                return {1'b1, m_reg[i][6][(p-4)*8 +: 8]};
            end
        end
        return 9'd0;
    endfunction

    task automatic wr(input int idx, input int sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_sel = 3'(sel); wr_data = d;
        @(posedge clk);
        if (sel == 7) m_cap = d;
        else          m_reg[idx][sel] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check(input string req, input logic [63:0] a);
        logic [8:0] exp;
        exp = ref_lookup(a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        n_checks++;
        if (res_valid !== 1'b1 || res_hit !== exp[8] || res_port !== exp[7:0]) begin
            n_errors++;
            $display("FAIL %s addr=%h actual v=%b hit=%b port=%h expected v=1 hit=%b port=%h",
                     req, a, res_valid, res_hit, res_port, exp[8], exp[7:0]);
        end
    endtask

    task automatic check_idle();
        @(negedge clk);
        n_checks++;
        if (res_valid !== 1'b0 || res_hit !== 1'b0 || res_port !== 8'd0) begin
            n_errors++;
            $display("FAIL R2 idle actual v=%b hit=%b port=%h expected 0 0 00",
                     res_valid, res_hit, res_port);
        end
    endtask

    initial begin
        logic [31:0] seed;
        seed = 32'd12345;
        void'($urandom(seed));
        m_cap = '0;
        for (int i = 0; i < 8; i++) for (int j = 0; j < 7; j++) m_reg[i][j] = '0;
        #9 rst_n = 1'b1;
        // R12 reset state
        @(negedge clk);
        n_checks++;
        if (res_valid !== 0 || res_hit !== 0 || res_port !== 0) begin
            n_errors++;
            $display("FAIL R12 reset actual v=%b hit=%b port=%h expected 0 0 00",
                     res_valid, res_hit, res_port);
        end
        check("R12 uncommitted after reset", 64'h0);

        // Decoder 0: base 1 GiB (low bits set, ignored: R4), size 512 MiB, committed, 1 way
        wr(0, 0, 32'h4FFF_FFFF); wr(0, 1, 0); wr(0, 2, 32'h2ABC_DEF0); wr(0, 3, 0);
        wr(0, 4, 32'h0000_0400); wr(0, 5, 32'h4433_2211); wr(0, 6, 32'h8877_6655);
        check("R4 base low bits ignored", 64'h4000_0000);
        check("R5 below base", 64'h3FFF_FFFF);
        check("R5 last byte", 64'h5FFF_FFFF);
        check("R5 limit excluded", 64'h6000_0000);
        check("R11 no match", 64'h1_0000_0000);
        check_idle();

        // Decoder 1 overlaps decoder 0 but is hidden by count code 0 (R10)
        wr(1, 0, 32'h0000_0000); wr(1, 1, 0); wr(1, 2, 0); wr(1, 3, 32'h1);
        wr(1, 4, 32'h0000_0423); wr(1, 5, 32'hD3C2_B1A0); wr(1, 6, 32'hF7E6_D5C4);
        check("R10 decoder beyond count", 64'h0000_1000);
        wr(0, 7, 32'h1);
        check("R6 lowest index wins", 64'h4000_0000);
        check("R9 position from second decoder", 64'h0000_1000);
        // R7: uncommitted first match hides later match
        wr(0, 4, 32'h0000_0000);
        check("R7 uncommitted first match", 64'h4000_0000);
        wr(0, 7, 32'h5);
        check("R10 bad count code", 64'h0000_1000);
        wr(0, 7, 32'h4);

        // R3/R8/R9 random configuration and lookups
        for (int r = 0; r < 20; r++) begin
            for (int i = 0; i < 8; i++) begin
                wr(i, 0, {4'($urandom_range(0, 15)), 28'($urandom)});
                wr(i, 1, 32'($urandom_range(0, 1)));
                wr(i, 2, {4'($urandom_range(1, 15)), 28'($urandom)});
                wr(i, 3, 32'($urandom_range(0, 1)));
                wr(i, 4, {21'd0, 1'($urandom_range(0, 4) != 0), 2'd0,
                          4'($urandom_range(0, 5)), 4'($urandom_range(0, 15))});
                wr(i, 5, $urandom);
                wr(i, 6, $urandom);
            end
            wr(0, 7, 32'($urandom_range(0, 6)));
            for (int k = 0; k < 40; k++)
                check("R8 R9 R3 random", {30'd0, 2'($urandom_range(0, 3)), $urandom});
        end
        check_idle();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule